// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a memory controller's ECC checker and keeps a record of the first error that checker reports. Each cycle the checker may raise a corrected (single-bit) pulse, an uncorrectable (multi-bit) pulse, or both. It also presents the 8-bit syndrome and the 32-bit address of the access. When capture is armed, the block latches the error class, the top 19 address bits and the syndrome into one 32-bit status/control register. After that it ignores every later error until software re-arms it.

Software reads the register over a plain write-strobe/read-data port. It clears the error flags by writing ones to them, and it sets three control bits in the same register: a scrub-disable bit, an NMI enable and a bus-error enable. The block drives level-type NMI and bus-error requests from the captured flags and their enables. It also pulses a scrub request for every corrected read while scrubbing is allowed. The actual scrub write-back is done elsewhere.

Register layout: bit 31 scrub disable (read/write), bits 30:12 address bits 31:13 (read-only), bits 11:4 syndrome (read-only), bit 3 bus-error enable (read/write), bit 2 NMI enable (read/write), bit 1 multi-bit flag (write-one-to-clear), bit 0 single-bit flag (write-one-to-clear).

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, `csr_rdata` reads 0 and `nmi_req`, `bus_err_req` and `scrub_req` are low.
- R2: A single-bit pulse while capture is armed sets bit 0. It also stores `ecc_addr[31:13]` in bits 30:12 and `ecc_syndrome` in bits 11:4. All of these are visible on `csr_rdata` from the clock edge that samples the pulse.
- R3: A multi-bit pulse while capture is armed sets bit 1 and leaves bit 0 at 0, storing address and syndrome as in R2. Bits 0 and 1 are never both 1.
- R4: When both pulses arrive in the same cycle while capture is armed, the multi-bit error is recorded (bit 1 = 1, bit 0 = 0).
- R5: Once an error is captured, later error pulses of either class change none of bits 30:0 until capture is re-armed.
- R6: A register write with bit 0 = 1 clears the single-bit flag, and a write with bit 1 = 1 clears the multi-bit flag. A 0 in either position leaves that flag unchanged.
- R7: Capture re-arms only on a write that has bits 0 and 1 both at 1. A write that clears one flag alone leaves capture disarmed, so later errors are still ignored.
- R8: Every write loads bits 31, 3 and 2 from the write data. Writes do not change bits 30:4.
- R9: `nmi_req` is high exactly while bit 0 and bit 2 are both 1.
- R10: `bus_err_req` is high exactly while bit 1 and bit 3 are both 1.
- R11: `scrub_req` is high for the one cycle after each cycle with a single-bit pulse, no multi-bit pulse and bit 31 = 0. This happens whether or not capture is armed. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_sbe | input | 1 | Corrected (single-bit) error pulse from the checker |
| ecc_mbe | input | 1 | Uncorrectable (multi-bit) error pulse from the checker |
| ecc_syndrome | input | 8 | Syndrome of the current access |
| ecc_addr | input | 32 | Address of the current access |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read value |
| nmi_req | output | 1 | NMI request level |
| bus_err_req | output | 1 | Bus-error request level |
| scrub_req | output | 1 | One-cycle scrub request for a corrected read |

## Verification
Captured fields, flags and control bits are due at the first rising edge after the pulse or write. `nmi_req` and `bus_err_req` follow from that state in the same cycle, and `scrub_req` is registered one edge after the pulse. The bench drives inputs on the falling edge and holds them for exactly one rising edge. It then checks every result at the next falling edge, before any other stimulus can reach the register. For the cases where the register must not change, the bench reads it back at that same point.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  localparam int REG_W         = 32;
  localparam int TAG_W         = 19;
  localparam int SYN_W         = 8;
  localparam int SBE_BIT       = 0;
  localparam int MBE_BIT       = 1;
  localparam int NMI_EN_BIT    = 2;
  localparam int BERR_EN_BIT   = 3;
  localparam int SYN_LSB       = 4;
  localparam int TAG_LSB       = SYN_LSB + SYN_W;
  localparam int SCRUB_DIS_BIT = TAG_LSB + TAG_W;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } ctrl_t;

  // Assemble the software-visible register image.
  function automatic logic [REG_W-1:0] pack_reg(ctrl_t c, logic [TAG_W-1:0] tag,
                                                logic [SYN_W-1:0] syn,
                                                logic mbe, logic sbe);
    return {c.scrub_dis, tag, syn, c.berr_en, c.nmi_en, mbe, sbe};
  endfunction

  // Pull the control fields out of a write word.
  function automatic ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
    ctrl_t c;
    c.scrub_dis = w[SCRUB_DIS_BIT];
    c.berr_en   = w[BERR_EN_BIT];
    c.nmi_en    = w[NMI_EN_BIT];
    return c;
  endfunction

endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_ctrl,
  output ctrl_t ctrl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_ctrl;
  end

endmodule

// File: rtl/ecc_cap_latch.sv
module ecc_cap_latch #(
  parameter int TAG_W = 19,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_in,
  input  logic             mbe_in,
  input  logic [SYN_W-1:0] syn_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             clr_sbe,
  input  logic             clr_mbe,
  input  logic             rearm,
  output logic             sbe_flag,
  output logic             mbe_flag,
  output logic             locked,
  output logic             capture,
  output logic [TAG_W-1:0] tag_q,
  output logic [SYN_W-1:0] syn_q
);

  // Capture is allowed only while no earlier event holds the register.
  assign capture = !locked && (sbe_in || mbe_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_flag <= 1'b0;
      mbe_flag <= 1'b0;
      locked   <= 1'b0;
      tag_q    <= '0;
      syn_q    <= '0;
    end else if (capture) begin
      mbe_flag <= mbe_in;          // multi-bit takes precedence
      sbe_flag <= !mbe_in;
      locked   <= 1'b1;
      tag_q    <= tag_in;
      syn_q    <= syn_in;
    end else begin
      if (clr_sbe) sbe_flag <= 1'b0;
      if (clr_mbe) mbe_flag <= 1'b0;
      if (rearm)   locked   <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq
  import ecc_cap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_q,
  input  logic  sbe_flag,
  input  logic  mbe_flag,
  input  logic  sbe_in,
  input  logic  mbe_in,
  output logic  nmi_req,
  output logic  bus_err_req,
  output logic  scrub_req
);

  logic scrub_hit;

  assign nmi_req     = sbe_flag && ctrl_q.nmi_en;
  assign bus_err_req = mbe_flag && ctrl_q.berr_en;
  assign scrub_hit   = sbe_in && !mbe_in && !ctrl_q.scrub_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) scrub_req <= 1'b0;
    else        scrub_req <= scrub_hit;
  end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_sbe,
  input  logic              ecc_mbe,
  input  logic [SYN_W-1:0]  ecc_syndrome,
  input  logic [ADDR_W-1:0] ecc_addr,
  input  logic              csr_wr,
  input  logic [REG_W-1:0]  csr_wdata,
  output logic [REG_W-1:0]  csr_rdata,
  output logic              nmi_req,
  output logic              bus_err_req,
  output logic              scrub_req
);

  localparam int TAG_LO = ADDR_W - TAG_W;

  ctrl_t            ctrl_q;
  logic             sbe_flag, mbe_flag, locked, capture;
  logic             clr_sbe, clr_mbe, rearm;
  logic [TAG_W-1:0] tag_q;
  logic [SYN_W-1:0] syn_q;
  logic             unused_bits;

  assign clr_sbe     = csr_wr && csr_wdata[SBE_BIT];
  assign clr_mbe     = csr_wr && csr_wdata[MBE_BIT];
  assign rearm       = clr_sbe && clr_mbe;
  assign unused_bits = ^{csr_wdata[SCRUB_DIS_BIT-1:SYN_LSB], ecc_addr[TAG_LO-1:0], capture};

  ecc_cap_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr),
    .wr_ctrl (unpack_ctrl(csr_wdata)),
    .ctrl_q  (ctrl_q)
  );

  ecc_cap_latch #(.TAG_W(TAG_W), .SYN_W(SYN_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .sbe_in   (ecc_sbe),
    .mbe_in   (ecc_mbe),
    .syn_in   (ecc_syndrome),
    .tag_in   (ecc_addr[ADDR_W-1:TAG_LO]),
    .clr_sbe  (clr_sbe),
    .clr_mbe  (clr_mbe),
    .rearm    (rearm),
    .sbe_flag (sbe_flag),
    .mbe_flag (mbe_flag),
    .locked   (locked),
    .capture  (capture),
    .tag_q    (tag_q),
    .syn_q    (syn_q)
  );

  ecc_cap_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_q),
    .sbe_flag    (sbe_flag),
    .mbe_flag    (mbe_flag),
    .sbe_in      (ecc_sbe),
    .mbe_in      (ecc_mbe),
    .nmi_req     (nmi_req),
    .bus_err_req (bus_err_req),
    .scrub_req   (scrub_req)
  );

  assign csr_rdata = pack_reg(ctrl_q, tag_q, syn_q, mbe_flag, sbe_flag);

endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ecc_sbe,
  input logic        ecc_mbe,
  input logic        csr_wr,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic        nmi_req,
  input logic        bus_err_req,
  input logic        scrub_req,
  input logic        sbe_flag,
  input logic        mbe_flag,
  input logic        locked,
  input logic        rearm
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sbe_flag && mbe_flag)); // R3

  AST_MBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && ecc_sbe && ecc_mbe) |=> (mbe_flag && !sbe_flag)); // R4

  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rearm) |=> $stable(csr_rdata[30:4])); // R5

  AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_flag && !(csr_wr && csr_wdata[0])) |=> sbe_flag); // R6

  AST_HALF_CLEAR_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && csr_wr && (csr_wdata[1:0] != 2'b11)) |=> locked); // R7

  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (csr_rdata[0] && csr_rdata[2])); // R9

  AST_BERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_req |-> (csr_rdata[1] && csr_rdata[3])); // R10

  AST_SCRUB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_sbe && !ecc_mbe && !csr_rdata[31]) |=> scrub_req); // R11

endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ecc_sbe     (ecc_sbe),
  .ecc_mbe     (ecc_mbe),
  .csr_wr      (csr_wr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .nmi_req     (nmi_req),
  .bus_err_req (bus_err_req),
  .scrub_req   (scrub_req),
  .sbe_flag    (sbe_flag),
  .mbe_flag    (mbe_flag),
  .locked      (locked),
  .rearm       (rearm)
);

// File: tb/ecc_err_capture_bench.sv
module ecc_err_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_sbe = 1'b0, ecc_mbe = 1'b0;
  logic [7:0]  ecc_syndrome = '0;
  logic [31:0] ecc_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        nmi_req, bus_err_req, scrub_req;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] A1 = 32'hDEADB123;
  localparam logic [31:0] A2 = 32'h12345678;
  localparam logic [31:0] A3 = 32'hFFFFE000;

  always #2.5 clk = ~clk;

  ecc_err_capture u_ecc_err_capture (
    .clk(clk), .rst_n(rst_n), .ecc_sbe(ecc_sbe), .ecc_mbe(ecc_mbe),
    .ecc_syndrome(ecc_syndrome), .ecc_addr(ecc_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .nmi_req(nmi_req),
    .bus_err_req(bus_err_req), .scrub_req(scrub_req)
  );

  // Expected register image from the layout stated in the brief.
  function automatic logic [31:0] exp_reg(logic sd, logic [31:0] a, logic [7:0] s,
                                          logic be, logic ne, logic mb, logic sb);
    logic [31:0] r;
    r = 32'd0;
    r[31]    = sd;
    r[30:12] = a >> 13;
    r[11:4]  = s;
    r[3]     = be;
    r[2]     = ne;
    r[1]     = mb;
    r[0]     = sb;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Hold a pulse for one rising edge; results are sampled at the following falling edge.
  task automatic pulse(input logic s, input logic m, input logic [7:0] syn, input logic [31:0] a);
    @(negedge clk);
    ecc_sbe = s; ecc_mbe = m; ecc_syndrome = syn; ecc_addr = a;
    @(negedge clk);
    ecc_sbe = 1'b0; ecc_mbe = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rdata", csr_rdata, 32'd0);
    check("R1 outputs", {29'd0, nmi_req, bus_err_req, scrub_req}, 32'd0);
  endtask

  task automatic t_first_capture;
    pulse(1, 0, 8'h5A, A1);
    check("R2 sbe capture", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 1));
    check("R11 scrub after corrected", {31'd0, scrub_req}, 32'd1);
    pulse(0, 1, 8'hC3, A2);
    check("R5 mbe ignored while held", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 1));
    check("R11 no scrub on mbe", {31'd0, scrub_req}, 32'd0);
    pulse(1, 0, 8'hC3, A2);
    check("R5 sbe ignored while held", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 1));
    check("R11 scrub while held", {31'd0, scrub_req}, 32'd1);
  endtask

  task automatic t_write_rules;
    wr(32'h7FFFFFF0);
    check("R6 R8 zero flags and ro field ignored", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 1));
    wr(32'h0000_0001);
    check("R6 w1c sbe", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 0));
    pulse(0, 1, 8'hC3, A2);
    check("R7 half clear stays disarmed", csr_rdata, exp_reg(0, A1, 8'h5A, 0, 0, 0, 0));
    check("R10 no bus error", {31'd0, bus_err_req}, 32'd0);
  endtask

  task automatic t_mbe_path;
    wr(32'h0000_0003);
    pulse(0, 1, 8'hC3, A2);
    check("R3 mbe capture after rearm", csr_rdata, exp_reg(0, A2, 8'hC3, 0, 0, 1, 0));
    check("R10 bus error gated off", {31'd0, bus_err_req}, 32'd0);
    wr(32'h0000_0008);
    check("R8 berr enable written", csr_rdata, exp_reg(0, A2, 8'hC3, 1, 0, 1, 0));
    check("R10 bus error level", {30'd0, bus_err_req, nmi_req}, 32'd2);
    wr(32'h0000_0002);
    check("R6 w1c mbe", csr_rdata, exp_reg(0, A2, 8'hC3, 0, 0, 0, 0));
    check("R10 bus error drops", {31'd0, bus_err_req}, 32'd0);
  endtask

  task automatic t_simultaneous;
    wr(32'h0000_0003);
    pulse(1, 1, 8'hFF, A3);
    check("R4 both same cycle", csr_rdata, exp_reg(0, A3, 8'hFF, 0, 0, 1, 0));
    check("R11 no scrub with mbe", {31'd0, scrub_req}, 32'd0);
  endtask

  task automatic t_nmi;
    wr(32'h0000_0007);
    check("R7 full clear", csr_rdata, exp_reg(0, A3, 8'hFF, 0, 1, 0, 0));
    check("R9 nmi idle", {31'd0, nmi_req}, 32'd0);
    pulse(1, 0, 8'h11, A1);
    check("R2 recapture", csr_rdata, exp_reg(0, A1, 8'h11, 0, 1, 0, 1));
    check("R9 nmi level", {30'd0, nmi_req, bus_err_req}, 32'd2);
    wr(32'h0000_0005);
    check("R9 nmi drops", {31'd0, nmi_req}, 32'd0);
  endtask

  task automatic t_scrub_disable;
    wr(32'h8000_0003);
    pulse(1, 0, 8'h22, A2);
    check("R11 scrub disabled", {31'd0, scrub_req}, 32'd0);
    check("R8 scrub disable bit", csr_rdata, exp_reg(1, A2, 8'h22, 0, 0, 0, 1));
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", csr_rdata, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_first_capture;
    t_write_rules;
    t_mbe_path;
    t_simultaneous;
    t_nmi;
    t_scrub_disable;
    t_reset_again;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule